// File: doc/BRIEF.md
# Dual-Style Multiplexed Host Bus Port

This block connects a host processor to a small register file over an 8-bit shared address/data bus. The bus carries an address strobe, an active-low chip select, a read/write line and a data strobe. A style input selects how the last two are read. With the style input high, the data strobe is a pulse and read/write is a level that gives the direction. With it low, the data strobe works as an output enable and read/write works as an active-low write enable. An unconnected style input is expected to sit low on the board, which gives the enable-style convention.

All bus inputs pass through a two-flop synchronizer into the system clock. The block latches the address on the address-strobe fall. It gives the register file exactly one read strobe or one write strobe per access, and it raises the bus drive enable while a read is being served. A power-fail input or a low device-reset input blocks every access. A chip-select miss or a new address-strobe rise throws the latched address away, so each access needs a fresh address phase.

The controller is a state machine with six states. ST_IDLE holds no valid address. ST_ARMED holds a valid address. ST_FETCH issues the read strobe. ST_DRIVE drives the bus. ST_WRITE waits for the write strobe to end. ST_COMMIT issues the write strobe. The transitions are as follows:
- ST_IDLE to ST_ARMED on an address-strobe fall.
- ST_ARMED back to ST_ARMED on a new address-strobe fall.
- ST_ARMED to ST_IDLE on an address-strobe rise, or when a strobe arrives while not selected.
- ST_ARMED to ST_FETCH on the read level while selected.
- ST_ARMED to ST_WRITE on the write level while selected.
- ST_FETCH to ST_DRIVE while the read level holds, otherwise to ST_IDLE.
- ST_DRIVE to ST_IDLE when the read level or the selection ends.
- ST_WRITE to ST_COMMIT when the write level ends while still selected, and to ST_IDLE when the selection is lost.
- ST_COMMIT to ST_IDLE unconditionally.

Top module: `hostbus_port`

## Requirements
- R1: While rst_n is low, bus_oe_o, reg_rd_o and reg_wr_o are 0.
- R2: A falling edge of as_i captures ad_i, and the captured value appears on reg_addr_o.
- R3: A rising edge of as_i invalidates the captured address, and a later data strobe with no new fall of as_i produces no register access.
- R4: With style_i=1, a write is rw_i=0 while ds_i is high. The data on ad_i is taken when ds_i falls, and one reg_wr_o pulse carries it with the captured address.
- R5: With style_i=1, a read is rw_i=1 while ds_i is high. bus_oe_o is 1 and bus_ad_o holds the register data during that read.
- R6: With style_i=0, a write is rw_i low. The data on ad_i is taken when rw_i rises, and one reg_wr_o pulse carries it with the captured address.
- R7: With style_i=0, a read is ds_i low. bus_oe_o is 1 and bus_ad_o holds the register data during that read.
- R8: Each access consumes the address. A read produces exactly one reg_rd_o pulse, and a second strobe without a new address phase accesses nothing.
- R9: With cs_n_i high, the address is still captured on reg_addr_o, but no reg_rd_o or reg_wr_o pulse occurs and bus_oe_o stays 0.
- R10: While pwr_fail_i is 1, no access occurs. A write whose strobe ends in the same cycle that pwr_fail_i rises is dropped.
- R11: While dev_rst_n_i is 0, no access occurs and bus_oe_o stays 0.
- R12: bus_oe_o falls on the second clock edge after ds_i leaves the read level, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| style_i | input | 1 | 1: pulse data strobe with level direction; 0: output-enable and write-enable style |
| as_i | input | 1 | Address strobe |
| ds_i | input | 1 | Data strobe or output enable |
| rw_i | input | 1 | Read/write level or active-low write enable |
| cs_n_i | input | 1 | Chip select, active low |
| pwr_fail_i | input | 1 | Supply below threshold; blocks access |
| dev_rst_n_i | input | 1 | Device reset input, active low; blocks access |
| ad_i | input | 8 | Address/data bus, input side |
| bus_ad_o | output | 8 | Read data toward the bus |
| bus_oe_o | output | 1 | Bus drive enable |
| reg_addr_o | output | 8 | Captured register address |
| reg_wdata_o | output | 8 | Write data toward the register file |
| reg_wr_o | output | 1 | Single-cycle register write strobe |
| reg_rd_o | output | 1 | Single-cycle register read strobe |
| reg_rdata_i | input | 8 | Read data from the register file |

## Verification
The two functions that can land in the same cycle are the end of a write strobe and the loss of selection through power fail. The bench lowers the data strobe (style 1) or raises write-enable (style 0) and raises pwr_fail_i in the same input step. Both signals then leave the synchronizer in the same clock cycle, so the controller sees them together. The correct result is that no reg_wr_o pulse appears. A sweep over both styles and eight addresses also checks that the drive enable drops on the exact edge after a read ends.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
package hbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FETCH,
        ST_DRIVE,
        ST_WRITE,
        ST_COMMIT
    } hb_state_t;
endpackage

// File: rtl/hbus_sync.sv
`timescale 1ns/1ps
module hbus_sync #(
    parameter int WIDTH = 8,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < STAGES; i++) begin : g_st
        logic [WIDTH-1:0] q_r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= RST_VAL;
                else        q_r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= RST_VAL;
                else        q_r <= g_st[i-1].q_r;
            end
        end
    end
    assign q = g_st[STAGES-1].q_r;
endmodule

// File: rtl/hbus_edge.sv
`timescale 1ns/1ps
module hbus_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig;
    end
    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/hbus_fsm.sv
`timescale 1ns/1ps
module hbus_fsm
    import hbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          style,
    input  logic          as_rise,
    input  logic          as_fall,
    input  logic          ds,
    input  logic          rw,
    input  logic          sel,
    input  logic [DW-1:0] ad,
    input  logic [DW-1:0] rdata_in,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe
);
    hb_state_t state_q, state_d;
    logic [DW-1:0] addr_q, wdata_q, rdata_q;
    logic rd_lvl, wr_lvl;

    assign rd_lvl = style ? (ds & rw)  : ~ds;
    assign wr_lvl = style ? (ds & ~rw) : ~rw;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (as_fall) state_d = ST_ARMED;
            ST_ARMED: begin
                if (as_rise)          state_d = ST_IDLE;
                else if (as_fall)     state_d = ST_ARMED;
                else if (rd_lvl)      state_d = sel ? ST_FETCH : ST_IDLE;
                else if (wr_lvl)      state_d = sel ? ST_WRITE : ST_IDLE;
            end
            ST_FETCH:  state_d = (rd_lvl && sel) ? ST_DRIVE : ST_IDLE;
            ST_DRIVE:  if (!(rd_lvl && sel)) state_d = ST_IDLE;
            ST_WRITE: begin
                if (!sel)         state_d = ST_IDLE;
                else if (!wr_lvl) state_d = ST_COMMIT;
            end
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (as_fall && (state_q == ST_IDLE || state_q == ST_ARMED))
                addr_q <= ad;
            if (state_q == ST_WRITE && !wr_lvl)
                wdata_q <= ad;
            if (state_q == ST_FETCH)
                rdata_q <= rdata_in;
        end
    end

    always_comb begin
        reg_addr  = addr_q;
        reg_wdata = wdata_q;
        ad_out    = rdata_q;
        reg_rd    = (state_q == ST_FETCH);
        reg_wr    = (state_q == ST_COMMIT);
        ad_oe     = (state_q == ST_DRIVE) && rd_lvl && sel;
    end

    assert_rd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_oe_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(reg_rd));
    assert_wr_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(state_q == ST_WRITE));
endmodule

// File: rtl/hostbus_port.sv
`timescale 1ns/1ps
module hostbus_port #(
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          style_i,
    input  logic          as_i,
    input  logic          ds_i,
    input  logic          rw_i,
    input  logic          cs_n_i,
    input  logic          pwr_fail_i,
    input  logic          dev_rst_n_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] bus_ad_o,
    output logic          bus_oe_o,
    output logic [DW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    output logic          reg_wr_o,
    output logic          reg_rd_o,
    input  logic [DW-1:0] reg_rdata_i
);
    localparam int CTL = 7;
    localparam int SW  = CTL + DW;
    localparam logic [SW-1:0] SYNC_RST = {7'b0000100, {DW{1'b0}}};

    logic [SW-1:0] raw, synced;
    logic style_s, as_s, ds_s, rw_s, cs_n_s, pf_s, drst_n_s;
    logic [DW-1:0] ad_s;
    logic as_rise, as_fall, sel;

    assign raw = {style_i, as_i, ds_i, rw_i, cs_n_i, pwr_fail_i, dev_rst_n_i, ad_i};

    hbus_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    assign {style_s, as_s, ds_s, rw_s, cs_n_s, pf_s, drst_n_s, ad_s} = synced;
    assign sel = ~cs_n_s & ~pf_s & drst_n_s;

    hbus_edge #(.RST_VAL(1'b0)) u_as_edge (
        .clk(clk), .rst_n(rst_n), .sig(as_s), .rise(as_rise), .fall(as_fall)
    );

    hbus_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .style(style_s),
        .as_rise(as_rise), .as_fall(as_fall),
        .ds(ds_s), .rw(rw_s), .sel(sel), .ad(ad_s),
        .rdata_in(reg_rdata_i),
        .reg_addr(reg_addr_o), .reg_wdata(reg_wdata_o),
        .reg_rd(reg_rd_o), .reg_wr(reg_wr_o),
        .ad_out(bus_ad_o), .ad_oe(bus_oe_o)
    );

    assert_pf_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pf_s) |-> (!reg_wr_o && !reg_rd_o));
    assert_cs_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_s) |-> (!reg_wr_o && !reg_rd_o));
    assert_devrst_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!drst_n_s) |-> (!reg_wr_o && !reg_rd_o));
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_o && reg_wr_o));
    always_comb begin
        if (!rst_n) assert_reset_quiet_R1: assert (!bus_oe_o && !reg_rd_o && !reg_wr_o);
    end
endmodule

// File: tb/hostbus_port_tb.sv
`timescale 1ns/1ps
module hostbus_port_tb;
    logic clk = 1'b0;
    logic rst_n, style, as_l, ds_l, rw_l, cs_n, pf, drst_n;
    logic [7:0] ad, bus_ad, reg_addr, reg_wdata, reg_rdata;
    logic bus_oe, reg_wr, reg_rd;
    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [7:0] wr_addr_seen, wr_data_seen, rd_addr_seen;

    always #5 clk = ~clk;

    hostbus_port u_dut (
        .clk(clk), .rst_n(rst_n), .style_i(style), .as_i(as_l), .ds_i(ds_l),
        .rw_i(rw_l), .cs_n_i(cs_n), .pwr_fail_i(pf), .dev_rst_n_i(drst_n),
        .ad_i(ad), .bus_ad_o(bus_ad), .bus_oe_o(bus_oe), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
        .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = reg_addr ^ 8'h5A;

    always @(posedge clk) begin
        if (reg_rd) begin rd_cnt <= rd_cnt + 1; rd_addr_seen <= reg_addr; end
        if (reg_wr) begin wr_cnt <= wr_cnt + 1; wr_addr_seen <= reg_addr; wr_data_seen <= reg_wdata; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_levels();
        ds_l = style ? 1'b0 : 1'b1;
        rw_l = 1'b1;
    endtask

    task automatic do_addr(input logic [7:0] a);
        as_l = 1'b1; ad = a; wcyc(4);
        as_l = 1'b0; wcyc(4);
        ad = 8'h00;
    endtask

    task automatic do_write(input logic [7:0] d, input bit pf_at_end);
        if (style) begin
            rw_l = 1'b0; ad = d; wcyc(3);
            ds_l = 1'b1; wcyc(4);
            ds_l = 1'b0; if (pf_at_end) pf = 1'b1; wcyc(4);
            rw_l = 1'b1; wcyc(3);
        end else begin
            ad = d; wcyc(2);
            rw_l = 1'b0; wcyc(4);
            rw_l = 1'b1; if (pf_at_end) pf = 1'b1; wcyc(4);
        end
    endtask

    task automatic do_read(output logic oe_on, output logic [7:0] dat,
                           output logic oe_e1, output logic oe_e2);
        if (style) ds_l = 1'b1; else ds_l = 1'b0;
        wcyc(6);
        oe_on = bus_oe; dat = bus_ad;
        idle_levels();
        wcyc(1); oe_e1 = bus_oe;
        wcyc(1); oe_e2 = bus_oe;
        wcyc(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic oe_on, oe_e1, oe_e2;
        logic [7:0] dat;
        int rc, wc;
        rst_n = 1'b0; style = 1'b0; as_l = 1'b0; cs_n = 1'b0; pf = 1'b0;
        drst_n = 1'b1; ad = 8'h00; idle_levels();
        wcyc(5);
        chk(!bus_oe && !reg_rd && !reg_wr, "R1 reset idle", {bus_oe, reg_rd, reg_wr}, 0);
        rst_n = 1'b1; wcyc(4);
        chk(rd_cnt == 0 && wr_cnt == 0, "R1 no strobes after reset", rd_cnt + wr_cnt, 0);

        for (int m = 0; m < 2; m++) begin
            style = m[0]; idle_levels(); wcyc(4);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] a, d;
                a = 8'(k * 37 + 3);
                d = 8'(a * 5 + 1);
                do_addr(a);
                chk(reg_addr == a, "R2 address captured", reg_addr, a);
                wc = wr_cnt;
                do_write(d, 1'b0);
                chk(wr_cnt == wc + 1, m ? "R4 one write pulse" : "R6 one write pulse", wr_cnt - wc, 1);
                chk(wr_addr_seen == a && wr_data_seen == d, m ? "R4 write addr/data" : "R6 write addr/data",
                    {wr_addr_seen, wr_data_seen}, {a, d});
                do_addr(a);
                rc = rd_cnt;
                do_read(oe_on, dat, oe_e1, oe_e2);
                chk(rd_cnt == rc + 1 && rd_addr_seen == a, "R8 exactly one read strobe", rd_cnt - rc, 1);
                chk(oe_on && dat == (a ^ 8'h5A), m ? "R5 read drive" : "R7 read drive", {oe_on, dat}, {1'b1, a ^ 8'h5A});
                chk(oe_e1 && !oe_e2, "R12 drive enable drop edge", {oe_e1, oe_e2}, 2'b10);
                if (k == 0) begin
                    rc = rd_cnt; wc = wr_cnt;
                    do_read(oe_on, dat, oe_e1, oe_e2);
                    do_write(8'h77, 1'b0);
                    chk(rd_cnt == rc && wr_cnt == wc && !oe_on, "R8 no access without new address",
                        (rd_cnt - rc) + (wr_cnt - wc), 0);
                end
            end

            // R3: AS rise invalidates the address
            do_addr(8'h21);
            as_l = 1'b1; wcyc(4);
            rc = rd_cnt;
            do_read(oe_on, dat, oe_e1, oe_e2);
            chk(rd_cnt == rc && !oe_on, "R3 AS rise clears address", rd_cnt - rc, 0);
            as_l = 1'b0; wcyc(4);

            // R9: chip select inactive
            cs_n = 1'b1;
            do_addr(8'h42);
            chk(reg_addr == 8'h42, "R9 address latched without select", reg_addr, 8'h42);
            rc = rd_cnt;
            do_read(oe_on, dat, oe_e1, oe_e2);
            chk(rd_cnt == rc && !oe_on, "R9 no read without select", rd_cnt - rc, 0);
            do_addr(8'h43); wc = wr_cnt;
            do_write(8'h99, 1'b0);
            chk(wr_cnt == wc, "R9 no write without select", wr_cnt - wc, 0);
            cs_n = 1'b0; wcyc(4);

            // R10: power fail blocks; coincident end of write is dropped
            pf = 1'b1;
            do_addr(8'h55); wc = wr_cnt;
            do_write(8'h11, 1'b0);
            chk(wr_cnt == wc, "R10 write blocked in power fail", wr_cnt - wc, 0);
            pf = 1'b0; wcyc(4);
            do_addr(8'h56); wc = wr_cnt;
            do_write(8'h12, 1'b1);
            chk(wr_cnt == wc, "R10 write dropped at coincident power fail", wr_cnt - wc, 0);
            pf = 1'b0; wcyc(4);

            // R11: device reset input blocks
            drst_n = 1'b0;
            do_addr(8'h66); rc = rd_cnt;
            do_read(oe_on, dat, oe_e1, oe_e2);
            chk(rd_cnt == rc && !oe_on, "R11 no read in device reset", rd_cnt - rc, 0);
            drst_n = 1'b1; wcyc(4);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule